// File: doc/BRIEF.md
# Programmable Interrupt Crossbar Router

This block takes a wide bank of incoming interrupt lines and steers one chosen input onto each of a set of output interrupt lines. Each output has a 9-bit selector that holds the index of the input it carries. Selectors are packed two to a 32-bit control word and written through a simple word-addressed write port. A read port returns the programmed values. An extra observation word holds two more selectors. These drive two debug lines, and they can tap any input whatever the normal routing is doing.

A selector value of zero routes nothing, so input line 0 is never carried. Any value at or above the number of implemented inputs also drives its line low. Every routed line and both debug lines pass through one register stage. Software programs the words once at bring-up, and the router then follows its inputs with a fixed delay of one clock.

Top module: `irq_xbar_router`

## Requirements
- R1: While and after reset, every selector is 0, every routed and debug output is low, and every word reads back as 0.
- R2: A selector holding a value v with 0 < v < N_IN makes its output equal, at each rising edge, to input bit v as sampled at the previous rising edge. The output has one clock of latency. For example, v = 0x67 carries input 103.
- R3: Routing word k (word address k, 0 ≤ k < N_OUT/2) holds the selector of output 2k in bits 8:0 and the selector of output 2k+1 in bits 24:16. A write changes both fields together, and the new selection governs the output from the next rising edge on.
- R4: The observation word at word address OBS_WORD (default 32) holds the selector for debug line 0 in bits 8:0 and the selector for debug line 1 in bits 17:9. These follow the same routing and latency rule as R2.
- R5: A selector value of 0 drives its output low, whatever the inputs do.
- R6: A selector value at or above N_IN (for example 128 or 0x1FF with N_IN = 128) drives its output low.
- R7: Bits outside the defined fields read as 0 and ignore writes. Writes to word addresses that map no register change nothing. Reads of such addresses return 0.
- R8: A debug selector and a routing selector may name the same input at the same time, and both outputs then carry that input in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | N_IN | Incoming interrupt lines, index 0 upward |
| wr_en | input | 1 | Write strobe for one word |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Word address of the read |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| irq_out | output | N_OUT | Routed interrupt outputs, registered |
| obs_out | output | 2 | Debug observation outputs, registered |

## Verification
Two things can happen in the same cycle. A selector write can land while the input it names is toggling, and a debug selector and a routing selector can name one input together. The bench provokes both by writing the routing word and the observation word with the same index while driving that input bit with a changing pattern. Random writes that also hit unmapped addresses are interleaved with input activity. A bench model holds the selector values it has written and predicts every output one edge ahead. That prediction uses the old selector in the cycle of the write and the new one afterwards, and all routed and debug lines are compared every cycle.

// File: rtl/irq_xbar_pkg.sv
package irq_xbar_pkg;

  localparam int SEL_W  = 9;
  localparam int WORD_W = 32;
  localparam int ODD_LSB = 16;
  localparam int OBS_HI_LSB = 9;

  typedef logic [SEL_W-1:0] sel_t;

  // A selector names a real line only when nonzero and below the input count.
  function automatic logic sel_live(input sel_t sel, input int n_in);
    return (sel != '0) && (int'(sel) < n_in);
  endfunction

  function automatic logic [WORD_W-1:0] pack_route(input sel_t even_s, input sel_t odd_s);
    logic [WORD_W-1:0] w;
    w = '0;
    w[SEL_W-1:0] = even_s;
    w[ODD_LSB +: SEL_W] = odd_s;
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] pack_obs(input sel_t lo_s, input sel_t hi_s);
    logic [WORD_W-1:0] w;
    w = '0;
    w[SEL_W-1:0] = lo_s;
    w[OBS_HI_LSB +: SEL_W] = hi_s;
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] route_mask();
    return pack_route('1, '1);
  endfunction

  function automatic logic [WORD_W-1:0] obs_mask();
    return pack_obs('1, '1);
  endfunction

endpackage

// File: rtl/irq_xbar_regfile.sv
module irq_xbar_regfile
  import irq_xbar_pkg::*;
#(
  parameter int N_OUT    = 8,
  parameter int ADDR_W   = 6,
  parameter int OBS_WORD = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output sel_t              sel_o [N_OUT+2]
);

  localparam int N_WORDS = N_OUT / 2;
  localparam int N_SEL   = N_OUT + 2;
  localparam int OBS_LO  = N_OUT;
  localparam int OBS_HI  = N_OUT + 1;

  sel_t sel_q [N_SEL];

  // Named decode events, visible to the assertions.
  logic [N_WORDS-1:0] route_hit;
  logic               obs_hit;

  assign obs_hit = wr_en && (wr_addr == ADDR_W'(OBS_WORD));

  genvar k;
  generate
    for (k = 0; k < N_WORDS; k++) begin : g_word
      assign route_hit[k] = wr_en && (wr_addr == ADDR_W'(k));

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          sel_q[2*k]   <= '0;
          sel_q[2*k+1] <= '0;
        end else if (route_hit[k]) begin
          sel_q[2*k]   <= wr_data[SEL_W-1:0];
          sel_q[2*k+1] <= wr_data[ODD_LSB +: SEL_W];
        end
      end

      AST_EVEN_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        route_hit[k] |=> sel_q[2*k] == $past(wr_data[SEL_W-1:0]));                // R3
      AST_ODD_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        route_hit[k] |=> sel_q[2*k+1] == $past(wr_data[ODD_LSB +: SEL_W]));       // R3
      AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!route_hit[k] && $past(rst_n)) |=> $stable(sel_q[2*k]) && $stable(sel_q[2*k+1])); // R7
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q[OBS_LO] <= '0;
      sel_q[OBS_HI] <= '0;
    end else if (obs_hit) begin
      sel_q[OBS_LO] <= wr_data[SEL_W-1:0];
      sel_q[OBS_HI] <= wr_data[OBS_HI_LSB +: SEL_W];
    end
  end

  AST_OBS_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    obs_hit |=> (sel_q[OBS_LO] == $past(wr_data[SEL_W-1:0])) &&
                (sel_q[OBS_HI] == $past(wr_data[OBS_HI_LSB +: SEL_W])));          // R4

  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_n |=> (sel_q[0] == '0) && (sel_q[OBS_LO] == '0));                         // R1

  // Read path: one word at a time, undefined bits fixed at zero.
  always_comb begin
    rd_data = '0;
    for (int w = 0; w < N_WORDS; w++) begin
      if (rd_addr == ADDR_W'(w)) rd_data = pack_route(sel_q[2*w], sel_q[2*w+1]);
    end
    if (rd_addr == ADDR_W'(OBS_WORD)) rd_data = pack_obs(sel_q[OBS_LO], sel_q[OBS_HI]);
  end

  always_comb begin
    if (rst_n && (int'(rd_addr) < N_WORDS))
      AST_RSVD_READ_ZERO: assert ((rd_data & ~route_mask()) == '0);                 // R7
  end

  always_comb begin
    for (int s = 0; s < N_SEL; s++) sel_o[s] = sel_q[s];
  end

endmodule

// File: rtl/irq_xbar_pick.sv
module irq_xbar_pick
  import irq_xbar_pkg::*;
#(
  parameter int N_IN = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] irq_in,
  input  sel_t            sel,
  output logic            q
);

  localparam int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1;

  logic             live;
  logic [IDX_W-1:0] idx;
  logic             tap;

  assign live = sel_live(sel, N_IN);
  assign idx  = sel[IDX_W-1:0];
  assign tap  = live ? irq_in[idx] : 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else        q <= tap;
  end

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == '0) |=> !q);                                                           // R5
  AST_RANGE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sel) >= N_IN) |=> !q);                                                   // R6
  AST_FOLLOW_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    live |=> q == $past(irq_in[idx]));                                             // R2
  AST_RESET_LOW: assert property (@(posedge clk)
    !rst_n |=> !q);                                                                // R1

endmodule

// File: rtl/irq_xbar_router.sv
module irq_xbar_router
  import irq_xbar_pkg::*;
#(
  parameter int N_IN     = 128,
  parameter int N_OUT    = 8,
  parameter int ADDR_W   = 6,
  parameter int OBS_WORD = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IN-1:0]   irq_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic [N_OUT-1:0]  irq_out,
  output logic [1:0]        obs_out
);

  localparam int N_SEL = N_OUT + 2;

  sel_t             sel_w [N_SEL];
  logic [N_SEL-1:0] line_q;

  irq_xbar_regfile #(
    .N_OUT    (N_OUT),
    .ADDR_W   (ADDR_W),
    .OBS_WORD (OBS_WORD)
  ) regs_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .sel_o   (sel_w)
  );

  // Routed lines and debug taps share one selector-to-flop slice each.
  genvar s;
  generate
    for (s = 0; s < N_SEL; s++) begin : g_line
      irq_xbar_pick #(.N_IN(N_IN)) pick_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .irq_in (irq_in),
        .sel    (sel_w[s]),
        .q      (line_q[s])
      );
    end
  endgenerate

  assign irq_out = line_q[N_OUT-1:0];
  assign obs_out = line_q[N_SEL-1:N_OUT];

  AST_SAME_TAP: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_w[0] == sel_w[N_OUT]) |=> irq_out[0] == obs_out[0]);                      // R8

endmodule

// File: tb/irq_xbar_router_tb.sv
module irq_xbar_router_tb_top;

  localparam int N_IN = 128;
  localparam int N_OUT = 8;
  localparam int ADDR_W = 6;
  localparam int OBS_WORD = 32;
  localparam int NS = N_OUT + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N_IN-1:0] irq_in = '0;
  logic wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic [N_OUT-1:0] irq_out;
  logic [1:0] obs_out;

  always #5 clk = ~clk;

  irq_xbar_router #(.N_IN(N_IN), .N_OUT(N_OUT), .ADDR_W(ADDR_W), .OBS_WORD(OBS_WORD)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_out(irq_out), .obs_out(obs_out)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [8:0] m_sel [NS];
  logic [NS-1:0] exp_line = '0;

  function automatic logic ref_bit(input logic [N_IN-1:0] v, input logic [8:0] s);
    if (s == 0 || s >= N_IN) return 1'b0;
    return ((v >> s) & 1) != 0;
  endfunction

  function automatic logic [31:0] ref_word(input logic [ADDR_W-1:0] a);
    if (a < N_OUT / 2) return {7'd0, m_sel[2*a+1], 7'd0, m_sel[2*a]};
    if (a == OBS_WORD) return {14'd0, m_sel[N_OUT+1], m_sel[N_OUT]};
    return 32'd0;
  endfunction

  function automatic string line_tag(input int i);
    if (m_sel[i] == 0) return "R5";
    if (m_sel[i] >= N_IN) return "R6";
    if (i >= N_OUT) return "R4 R8";
    return "R2 R3";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // At a falling edge: compare, then drive next stimulus and predict the next edge.
  task automatic cycle(input bit we, input logic [ADDR_W-1:0] wa, input logic [31:0] wd,
                       input logic [N_IN-1:0] vin, input logic [ADDR_W-1:0] ra);
    logic [NS-1:0] got;
    @(negedge clk);
    got = {obs_out, irq_out};
    for (int i = 0; i < NS; i++) check(line_tag_prev[i], 32'(got[i]), 32'(exp_line[i]));
    check((rd_addr < N_OUT / 2) ? "R3 R7" : (rd_addr == OBS_WORD ? "R4" : "R7"),
          rd_data, ref_word(rd_addr));
    irq_in = vin; wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
    for (int i = 0; i < NS; i++) begin
      exp_line[i] = ref_bit(vin, m_sel[i]);
      line_tag_prev[i] = line_tag(i);
    end
    if (we) begin
      if (wa < N_OUT / 2) begin
        m_sel[2*wa] = wd[8:0]; m_sel[2*wa+1] = wd[24:16];
      end else if (wa == OBS_WORD) begin
        m_sel[N_OUT] = wd[8:0]; m_sel[N_OUT+1] = wd[17:9];
      end
    end
  endtask

  string line_tag_prev [NS];

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [N_IN-1:0] v;
    void'($urandom(32'd2024));
    for (int i = 0; i < NS; i++) begin m_sel[i] = '0; line_tag_prev[i] = "R1"; end
    irq_in = '1;
    repeat (3) @(negedge clk);
    // R1: reset state with inputs all high
    check("R1", 32'({obs_out, irq_out}), 32'd0);
    for (int a = 0; a < 40; a++) begin
      rd_addr = ADDR_W'(a); #1;
      check("R1", rd_data, 32'd0);
    end
    rd_addr = '0;
    @(negedge clk); rst_n = 1'b1;
    exp_line = '0;
    // R5: zero selectors keep lines low under busy inputs
    for (int c = 0; c < 4; c++) cycle(0, 0, 0, '1, 0);
    // R2 R3: 0x67 carries input 103 on output 0
    cycle(1, 0, 32'h0000_0067, '0, 0);
    for (int c = 0; c < 6; c++) cycle(0, 0, 0, (c % 2) ? '0 : (128'(1) << 103), 0);
    // R8 R4: observation taps the same input as output 0 and output 1 of word 0
    cycle(1, OBS_WORD, 32'h67 | (32'h67 << 9), 128'(1) << 103, OBS_WORD);
    cycle(1, 0, 32'h0067_0067, 128'(1) << 103, 0);
    for (int c = 0; c < 6; c++) cycle(0, 0, 0, (c % 2) ? (128'(1) << 103) : '0, OBS_WORD);
    // R6: boundary and max out-of-range, next to top valid index
    cycle(1, 1, {7'd0, 9'd127, 7'd0, 9'd128}, '1, 1);
    cycle(1, 2, {7'd0, 9'h1FF, 7'd0, 9'd1}, '1, 2);
    for (int c = 0; c < 4; c++) cycle(0, 0, 0, (c % 2) ? '1 : '0, 1);
    // R7: reserved bits and unmapped words
    cycle(1, 3, 32'hFFFF_FFFF, '1, 3);
    cycle(1, 20, 32'h0001_0002, '1, 20);
    cycle(1, OBS_WORD + 1, 32'h0000_0003, '1, 0);
    for (int c = 0; c < 3; c++) cycle(0, 0, 0, '1, 3);
    // Random mix
    for (int c = 0; c < 3000; c++) begin
      for (int b = 0; b < N_IN; b += 32) v[b +: 32] = $urandom;
      case ($urandom_range(0, 3))
        0: cycle(1, ADDR_W'($urandom_range(0, 40)), $urandom, v, ADDR_W'($urandom_range(0, 40)));
        1: cycle(1, ($urandom_range(0, 1) != 0) ? ADDR_W'(OBS_WORD) : ADDR_W'($urandom_range(0, 3)),
                 {7'd0, 9'($urandom_range(0, 140)), 7'd0, 9'($urandom_range(0, 140))} |
                 32'($urandom_range(0, 140) << 9) & 32'h3FE00, v, ADDR_W'(OBS_WORD));
        default: cycle(0, 0, 0, v, ADDR_W'($urandom_range(0, 3)));
      endcase
    end
    cycle(0, 0, 0, '0, 0);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule